// File: doc/BRIEF.md
# Dual-Convention Microprocessor Bus Slave

This block lets an 8-bit host processor read and write an on-chip register file over an asynchronous parallel bus. Two strap inputs are captured while reset is held. The first picks how the two strobe pins are read: either a direction line plus a data strobe, or separate active-low read and write strobes. The second picks how the register address arrives: either latched from the multiplexed address/data lines by an address-latch pulse, or written indirectly, with a select line marking each write as address or data. The host bus is asynchronous, so every pin passes through a two-flop synchronizer, and the block acts only on edges seen in the system clock domain.

A `bus_ready` handshake tells the host when the previous access has finished. The data lines are modelled as separate value and enable outputs, because the pad itself is outside the block. Toward the core, a plain register port issues one-cycle write and read strobes, and read data returns a fixed number of clocks after the read strobe. The port is a register-access path, not a stream, so it carries no valid/ready back-pressure. The host paces itself on `bus_ready` instead. An interrupt output takes a core event and presents it as a held level or as a fixed-width pulse, with either polarity.

Top module: `pbus_slave`

## Requirements
- R1: `mode_strobe` and `mode_addr` are captured on every clock while `rst_n` is low. After reset is released, changing these pins has no effect on how the bus is decoded.
- R2: With strobe mode 0, `bus_pin_a` high means read and low means write, and `bus_pin_b` low is the data strobe. With strobe mode 1, `bus_pin_a` low is the read strobe and `bus_pin_b` low is the write strobe.
- R3: A write takes effect when its strobe is released, using the `bus_ad_in` value held at that moment. It produces a one-cycle `rf_wr_en` carrying that data.
- R4: With address mode 0, a falling edge on `bus_asel` while chip select is active loads `bus_ad_in` into the register address used by later reads and writes. In this mode every write is a data write.
- R5: With address mode 1, a write released while `bus_asel`=1 loads the address register and does not write the register file. A write released while `bus_asel`=0 writes data to the current address, and the address is not incremented.
- R6: While `bus_cs_n` is high, strobes are ignored: no register write occurs, `bus_ready` stays high and `bus_ad_oe` stays low.
- R7: `bus_ready` is high after reset and when idle. It is low for exactly WR_LAT clocks after a detected write, then returns high.
- R8: A detected read issues `rf_rd_en` and holds `bus_ready` low for RD_LAT clocks. When `bus_ready` returns high, `bus_ad_out` shows the register value while the read strobe is held.
- R9: `bus_ad_oe` is high only while chip select is active and a read strobe is asserted. Otherwise it is low.
- R10: In level mode (`irq_pulse_mode`=0), the interrupt is asserted from the clock after `irq_event` until a clock with `irq_clear` and no event. An event and a clear in the same clock leave it asserted.
- R11: In pulse mode, each `irq_event` asserts the interrupt for exactly PULSE_W clocks. A new event restarts the count.
- R12: With `irq_active_high`=1, an asserted interrupt drives `irq_out`=1 and an idle one drives 0. With `irq_active_high`=0, the levels are inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; strap pins are sampled while low |
| mode_strobe | input | 1 | Strobe-convention strap (0 direction+strobe, 1 read/write strobes) |
| mode_addr | input | 1 | Addressing strap (0 address latch, 1 address/data select) |
| bus_cs_n | input | 1 | Active-low chip select |
| bus_pin_a | input | 1 | Direction line or read strobe, by strap |
| bus_pin_b | input | 1 | Data strobe or write strobe, by strap |
| bus_asel | input | 1 | Address latch pulse or address/data select, by strap |
| bus_ad_in | input | 8 | Multiplexed address/data lines, inbound |
| bus_ad_out | output | 8 | Read data toward the pad |
| bus_ad_oe | output | 1 | Pad drive enable for read data |
| bus_ready | output | 1 | High when the next access may start |
| rf_wr_en | output | 1 | One-cycle register write strobe |
| rf_rd_en | output | 1 | One-cycle register read strobe |
| rf_addr | output | 8 | Register address |
| rf_wdata | output | 8 | Register write data |
| rf_rdata | input | 8 | Register read data, valid RD_LAT clocks after `rf_rd_en` |
| irq_event | input | 1 | Core interrupt event |
| irq_clear | input | 1 | Clears the pending level interrupt |
| irq_active_high | input | 1 | Interrupt polarity |
| irq_pulse_mode | input | 1 | 1 selects pulse signalling, 0 level |
| irq_out | output | 1 | Interrupt output |

## Verification
The bench runs all four strap combinations. In each one it writes sixteen addresses with data that depends on both the address and the configuration, then reads them all back. A mix-up between the two strobe conventions or the two addressing schemes therefore shows up as wrong data at specific addresses rather than a simple pass or fail. Writes with chip select inactive, and strap changes after reset, are followed by read-backs to show that nothing changed. The interrupt is tried in level and pulse modes under both polarities, including an event coinciding with a clear and a retriggered pulse, which tell apart held, restarted and inverted outputs.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  typedef enum logic {
    STB_DIR_DS = 1'b0,
    STB_RD_WR  = 1'b1
  } stb_style_e;

  typedef enum logic {
    ADR_LATCH  = 1'b0,
    ADR_SELECT = 1'b1
  } adr_style_e;

  localparam int unsigned BUS_W = 8;
endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST;
      q    <= RST;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pbus_decode.sv
module pbus_decode
  import pbus_pkg::*;
#(
  parameter int unsigned DW = BUS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  stb_style_e    cfg_stb,
  input  adr_style_e    cfg_adr,
  input  logic          cs_n_s,
  input  logic          a_s,
  input  logic          b_s,
  input  logic          asel_s,
  input  logic [DW-1:0] ad_s,
  output logic          rd_act,
  output logic          rd_start,
  output logic          wr_evt,
  output logic          wr_is_addr,
  output logic [DW-1:0] wr_data,
  output logic [DW-1:0] addr_q
);
  logic          cs;
  logic          wr_act;
  logic          rd_prev, wr_prev;
  logic          ale_act, ale_prev;
  logic [DW-1:0] ale_hold;
  logic [DW-1:0] wd_hold;
  logic          sel_hold;

  assign cs = !cs_n_s;

  always_comb begin
    if (cfg_stb == STB_DIR_DS) begin
      rd_act = cs && !b_s && a_s;
      wr_act = cs && !b_s && !a_s;
    end else begin
      rd_act = cs && !a_s;
      wr_act = cs && !b_s;
    end
  end

  assign ale_act    = cs && asel_s && (cfg_adr == ADR_LATCH);
  assign rd_start   = rd_act && !rd_prev;
  assign wr_evt     = wr_prev && !wr_act;
  assign wr_is_addr = (cfg_adr == ADR_SELECT) && sel_hold;
  assign wr_data    = wd_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_prev  <= 1'b0;
      wr_prev  <= 1'b0;
      ale_prev <= 1'b0;
      ale_hold <= '0;
      wd_hold  <= '0;
      sel_hold <= 1'b0;
      addr_q   <= '0;
    end else begin
      rd_prev  <= rd_act;
      wr_prev  <= wr_act;
      ale_prev <= ale_act;
      if (ale_act) ale_hold <= ad_s;
      if (wr_act) begin
        wd_hold  <= ad_s;
        sel_hold <= asel_s;
      end
      if (ale_prev && !ale_act) addr_q <= ale_hold;
      else if (wr_evt && wr_is_addr) addr_q <= wd_hold;
    end
  end

  assert_rd_wr_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_act, wr_act}));

  assert_no_access_without_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |-> !(rd_act || wr_act || ale_act));

  assert_addr_only_on_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ale_prev && !ale_act) && !(wr_evt && wr_is_addr) |=> $stable(addr_q));
endmodule

// File: rtl/pbus_irq.sv
module pbus_irq #(
  parameter int unsigned PULSE_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_event,
  input  logic irq_clear,
  input  logic irq_active_high,
  input  logic irq_pulse_mode,
  output logic irq_out
);
  localparam int unsigned PCW = $clog2(PULSE_W + 1);

  logic           pend;
  logic [PCW-1:0] pcnt;
  logic           asrt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      pcnt <= '0;
    end else begin
      if (irq_event)      pend <= 1'b1;
      else if (irq_clear) pend <= 1'b0;
      if (irq_event)         pcnt <= PCW'(PULSE_W);
      else if (pcnt != '0)   pcnt <= pcnt - 1'b1;
    end
  end

  assign asrt    = irq_pulse_mode ? (pcnt != '0) : pend;
  assign irq_out = irq_active_high ? asrt : !asrt;

  assert_level_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_event |=> pend);

  assert_level_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clear && !irq_event) |=> !pend);

  assert_pulse_bounded_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= PCW'(PULSE_W));

  assert_pulse_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_event |=> (pcnt == PCW'(PULSE_W)));
endmodule

// File: rtl/pbus_slave.sv
module pbus_slave
  import pbus_pkg::*;
#(
  parameter int unsigned WR_LAT  = 2,
  parameter int unsigned RD_LAT  = 1,
  parameter int unsigned PULSE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_strobe,
  input  logic             mode_addr,
  input  logic             bus_cs_n,
  input  logic             bus_pin_a,
  input  logic             bus_pin_b,
  input  logic             bus_asel,
  input  logic [BUS_W-1:0] bus_ad_in,
  output logic [BUS_W-1:0] bus_ad_out,
  output logic             bus_ad_oe,
  output logic             bus_ready,
  output logic             rf_wr_en,
  output logic             rf_rd_en,
  output logic [BUS_W-1:0] rf_addr,
  output logic [BUS_W-1:0] rf_wdata,
  input  logic [BUS_W-1:0] rf_rdata,
  input  logic             irq_event,
  input  logic             irq_clear,
  input  logic             irq_active_high,
  input  logic             irq_pulse_mode,
  output logic             irq_out
);
  localparam int unsigned MAXLAT = (WR_LAT > RD_LAT) ? WR_LAT : RD_LAT;
  localparam int unsigned CW     = $clog2(MAXLAT + 1);
  localparam int unsigned SW     = BUS_W + 4;
  localparam logic [SW-1:0] SYNC_RST = {1'b1, 1'b1, 1'b1, 1'b0, {BUS_W{1'b0}}};

  stb_style_e cfg_stb;
  adr_style_e cfg_adr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_stb <= stb_style_e'(mode_strobe);
      cfg_adr <= adr_style_e'(mode_addr);
    end
  end

  logic [SW-1:0]    raw, syn;
  logic             cs_n_s, a_s, b_s, asel_s;
  logic [BUS_W-1:0] ad_s;

  assign raw = {bus_cs_n, bus_pin_a, bus_pin_b, bus_asel, bus_ad_in};
  assign {cs_n_s, a_s, b_s, asel_s, ad_s} = syn;

  pbus_sync #(.W(SW), .RST(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  logic             rd_act, rd_start, wr_evt, wr_is_addr;
  logic [BUS_W-1:0] wr_data, addr_q;

  pbus_decode #(.DW(BUS_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .cfg_stb(cfg_stb), .cfg_adr(cfg_adr),
    .cs_n_s(cs_n_s), .a_s(a_s), .b_s(b_s), .asel_s(asel_s), .ad_s(ad_s),
    .rd_act(rd_act), .rd_start(rd_start), .wr_evt(wr_evt),
    .wr_is_addr(wr_is_addr), .wr_data(wr_data), .addr_q(addr_q)
  );

  logic          idle;
  logic [CW-1:0] cnt;
  logic          rd_mode;
  logic [BUS_W-1:0] rdata_q;
  logic          acc_wr, acc_rd;

  assign idle     = (cnt == '0);
  assign acc_wr   = idle && wr_evt;
  assign acc_rd   = idle && !wr_evt && rd_start;
  assign rf_wr_en = acc_wr && !wr_is_addr;
  assign rf_rd_en = acc_rd;
  assign rf_addr  = addr_q;
  assign rf_wdata = wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      rd_mode   <= 1'b0;
      bus_ready <= 1'b1;
      rdata_q   <= '0;
    end else if (idle) begin
      if (acc_wr) begin
        cnt       <= CW'(WR_LAT);
        rd_mode   <= 1'b0;
        bus_ready <= 1'b0;
      end else if (acc_rd) begin
        cnt       <= CW'(RD_LAT);
        rd_mode   <= 1'b1;
        bus_ready <= 1'b0;
      end
    end else begin
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) begin
        bus_ready <= 1'b1;
        if (rd_mode) rdata_q <= rf_rdata;
      end
    end
  end

  assign bus_ad_out = rdata_q;
  assign bus_ad_oe  = rd_act;

  pbus_irq #(.PULSE_W(PULSE_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .irq_event(irq_event), .irq_clear(irq_clear),
    .irq_active_high(irq_active_high), .irq_pulse_mode(irq_pulse_mode),
    .irq_out(irq_out)
  );

  assert_cfg_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($stable(cfg_stb) && $stable(cfg_adr)));

  assert_write_drops_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |=> !bus_ready);

  assert_read_drops_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rf_rd_en |=> !bus_ready);

  assert_busy_counts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ready |-> (cnt != '0));

  assert_oe_needs_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ad_oe |-> !cs_n_s);
endmodule

// File: tb/pbus_slave_bench.sv
module pbus_slave_bench;
  localparam int WR_LAT = 2;
  localparam int RD_LAT = 1;
  localparam int PULSE_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_strobe = 1'b0, mode_addr = 1'b0;
  logic bus_cs_n = 1'b1, bus_pin_a = 1'b1, bus_pin_b = 1'b1, bus_asel = 1'b0;
  logic [7:0] bus_ad_in = '0;
  logic [7:0] bus_ad_out;
  logic bus_ad_oe, bus_ready, rf_wr_en, rf_rd_en;
  logic [7:0] rf_addr, rf_wdata;
  logic [7:0] rf_rdata = '0;
  logic irq_event = 1'b0, irq_clear = 1'b0, irq_active_high = 1'b1, irq_pulse_mode = 1'b0;
  logic irq_out;

  always #4 clk = ~clk;

  pbus_slave #(.WR_LAT(WR_LAT), .RD_LAT(RD_LAT), .PULSE_W(PULSE_W)) u_pbus_slave (
    .clk(clk), .rst_n(rst_n), .mode_strobe(mode_strobe), .mode_addr(mode_addr),
    .bus_cs_n(bus_cs_n), .bus_pin_a(bus_pin_a), .bus_pin_b(bus_pin_b),
    .bus_asel(bus_asel), .bus_ad_in(bus_ad_in), .bus_ad_out(bus_ad_out),
    .bus_ad_oe(bus_ad_oe), .bus_ready(bus_ready), .rf_wr_en(rf_wr_en),
    .rf_rd_en(rf_rd_en), .rf_addr(rf_addr), .rf_wdata(rf_wdata),
    .rf_rdata(rf_rdata), .irq_event(irq_event), .irq_clear(irq_clear),
    .irq_active_high(irq_active_high), .irq_pulse_mode(irq_pulse_mode),
    .irq_out(irq_out)
  );

  // register file model: one-clock read latency
  logic [7:0] mem [0:255];
  always_ff @(posedge clk) begin
    if (rf_wr_en) mem[rf_addr] <= rf_wdata;
    if (rf_rd_en) rf_rdata <= mem[rf_addr];
  end

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int cur_s = 0, cur_a = 0;
  logic [7:0] expv [0:15];

  function automatic void chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(int s, int a);
    rst_n = 1'b0; mode_strobe = s[0]; mode_addr = a[0];
    cur_s = s; cur_a = a;
    tick(4);
    rst_n = 1'b1;
    tick(2);
  endtask

  task automatic strobe_write(input logic [7:0] d, input logic sel, input bit cs_on,
                              output int lowcnt);
    bus_ad_in = d; bus_asel = sel; bus_cs_n = !cs_on;
    if (cur_s == 0) bus_pin_a = 1'b0;
    tick(1);
    bus_pin_b = 1'b0;
    tick(4);
    bus_pin_b = 1'b1;
    lowcnt = 0;
    for (int i = 0; i < 12; i++) begin
      tick(1);
      if (!bus_ready) lowcnt++;
    end
    bus_cs_n = 1'b1; bus_pin_a = 1'b1; bus_asel = 1'b0;
    tick(1);
  endtask

  task automatic ale_latch(input logic [7:0] a);
    bus_ad_in = a; bus_cs_n = 1'b0; bus_asel = 1'b1;
    tick(3);
    bus_asel = 1'b0;
    tick(3);
    bus_cs_n = 1'b1;
    tick(1);
  endtask

  task automatic set_addr(input logic [7:0] a);
    int lc;
    if (cur_a == 0) ale_latch(a);
    else begin
      strobe_write(a, 1'b1, 1'b1, lc);
      chk(lc == WR_LAT, "R5 address write ready width", lc, WR_LAT);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
    int lc;
    set_addr(a);
    strobe_write(d, 1'b0, 1'b1, lc);
    chk(lc == WR_LAT, "R7 write ready width", lc, WR_LAT);
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [7:0] d,
                          output int lowcnt, output logic oe);
    set_addr(a);
    bus_cs_n = 1'b0;
    if (cur_s == 0) begin
      bus_pin_a = 1'b1; tick(1); bus_pin_b = 1'b0;
    end else begin
      tick(1); bus_pin_a = 1'b0;
    end
    lowcnt = 0;
    for (int i = 0; i < 10; i++) begin
      tick(1);
      if (!bus_ready) lowcnt++;
    end
    d = bus_ad_out; oe = bus_ad_oe;
    bus_pin_a = 1'b1; bus_pin_b = 1'b1; bus_cs_n = 1'b1;
    tick(3);
    chk(bus_ad_oe == 1'b0, "R9 oe released after read", bus_ad_oe, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int lc;
    logic oe;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    tick(2);
    chk(bus_ready == 1'b1, "R7 ready high in reset", bus_ready, 1);
    chk(bus_ad_oe == 1'b0, "R9 oe low in reset", bus_ad_oe, 0);

    // sweep the four strap combinations (R1 R2 R3 R4 R5 R8)
    for (int cfg = 0; cfg < 4; cfg++) begin
      do_reset(cfg & 1, cfg >> 1);
      chk(bus_ready == 1'b1, "R7 ready idle after reset", bus_ready, 1);
      for (int a = 0; a < 16; a++) begin
        expv[a] = 8'((a * 29 + cfg * 61 + 5) & 255);
        reg_write(8'(a), expv[a]);
      end
      for (int a = 0; a < 16; a++) begin
        reg_read(8'(a), rd, lc, oe);
        chk(rd == expv[a], "R3 R2 R4 read back", rd, expv[a]);
        chk(lc == RD_LAT, "R8 read ready width", lc, RD_LAT);
        chk(oe == 1'b1, "R9 oe during read", oe, 1);
      end
      // chip select inactive: no write, no ready drop (R6)
      set_addr(8'd3);
      strobe_write(8'hEE, 1'b0, 1'b0, lc);
      chk(lc == 0, "R6 ready unaffected without cs", lc, 0);
      reg_read(8'd3, rd, lc, oe);
      chk(rd == expv[3], "R6 register unchanged without cs", rd, expv[3]);
    end

    // select mode: no auto-increment (R5)
    do_reset(1, 1);
    set_addr(8'd5);
    strobe_write(8'h11, 1'b0, 1'b1, lc);
    strobe_write(8'h22, 1'b0, 1'b1, lc);
    reg_read(8'd6, rd, lc, oe);
    chk(rd == expv[6], "R5 next address untouched", rd, expv[6]);
    reg_read(8'd5, rd, lc, oe);
    chk(rd == 8'h22, "R5 same address rewritten", rd, 8'h22);

    // strap pins changed after reset are ignored (R1)
    mode_strobe = 1'b0; mode_addr = 1'b0;
    tick(2);
    reg_write(8'd9, 8'h5A);
    reg_read(8'd9, rd, lc, oe);
    chk(rd == 8'h5A, "R1 latched strap still used", rd, 8'h5A);

    // interrupt polarity at idle (R12)
    irq_pulse_mode = 1'b0; irq_active_high = 1'b1; tick(1);
    chk(irq_out == 1'b0, "R12 idle active-high", irq_out, 0);
    irq_active_high = 1'b0; tick(1);
    chk(irq_out == 1'b1, "R12 idle active-low", irq_out, 1);
    irq_active_high = 1'b1;

    // level mode (R10)
    irq_event = 1'b1; tick(1); irq_event = 1'b0;
    chk(irq_out == 1'b1, "R10 level asserted", irq_out, 1);
    tick(6);
    chk(irq_out == 1'b1, "R10 level held", irq_out, 1);
    irq_event = 1'b1; irq_clear = 1'b1; tick(1); irq_event = 1'b0; irq_clear = 1'b0;
    chk(irq_out == 1'b1, "R10 event beats clear", irq_out, 1);
    irq_active_high = 1'b0; #1;
    chk(irq_out == 1'b0, "R12 asserted active-low", irq_out, 0);
    irq_active_high = 1'b1;
    irq_clear = 1'b1; tick(1); irq_clear = 1'b0;
    chk(irq_out == 1'b0, "R10 cleared", irq_out, 0);

    // pulse mode (R11)
    irq_pulse_mode = 1'b1; tick(1);
    begin
      int cnt = 0;
      irq_event = 1'b1; tick(1); irq_event = 1'b0;
      for (int i = 0; i < 10; i++) begin
        if (irq_out) cnt++;
        tick(1);
      end
      chk(cnt == PULSE_W, "R11 pulse width", cnt, PULSE_W);
    end
    begin
      int cnt = 0;
      irq_active_high = 1'b0; tick(1);
      irq_event = 1'b1; tick(1); irq_event = 1'b0;
      if (!irq_out) cnt++;
      tick(1);
      if (!irq_out) cnt++;
      irq_event = 1'b1; tick(1); irq_event = 1'b0;
      for (int i = 0; i < 10; i++) begin
        if (!irq_out) cnt++;
        tick(1);
      end
      chk(cnt == PULSE_W + 2, "R11 R12 retriggered low pulse", cnt, PULSE_W + 2);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule